// File: doc/BRIEF.md
# Fractional Complex Multiplier with Operand Conjugation

This block multiplies two complex operands, X and Y. Each one has a real part and an imaginary part, and each part is a 16-bit two's-complement fraction. The block returns the real and imaginary parts of the product, each as a 16-bit fraction. X and Y each have their own capture register with its own load enable, so one operand can stay fixed while the other changes every cycle.

Either operand can be conjugated as it is used, at no cost in throughput. One round control applies to both result parts. The two results are computed at full internal precision, then rounded or truncated, and then saturated.

The product of two -1 factors cannot be represented as a fraction. Any such partial product is clamped to the largest positive value. The output stage drives zero on any part whose enable is low, and a valid flag travels through the pipeline beside the data.

Top module: `cplx_frac_mul`

## Requirements
- R1: With rounding off, `p_re` equals the floor of (XR·YR − XI·YI) / 2^15, saturated to the range [0x8000, 0x7FFF]. XR, XI, YR and YI are the captured operand parts, after any conjugation.
- R2: With rounding off, `p_im` equals the floor of (XR·YI + XI·YR) / 2^15, saturated in the same way as R1.
- R3: Operands and controls are sampled on a rising edge. The matching result and `p_vld` appear after the third rising edge that follows. `p_vld` is high exactly when `x_ld` or `y_ld` was high at the sampling edge.
- R4: The X register (`x_re`, `x_im`, `conj_x`) loads only on edges where `x_ld` is high. The Y register (`y_re`, `y_im`, `conj_y`) loads only on edges where `y_ld` is high. While neither loads and `rnd`, `re_en` and `im_en` stay constant, both outputs hold their values.
- R5: When the captured `conj_x` is 1, the imaginary part of X is negated before multiplication. Negating 0x8000 gives 0x7FFF.
- R6: When the captured `conj_y` is 1, the imaginary part of Y is negated in the same way, with 0x8000 becoming 0x7FFF.
- R7: A partial product whose two factors are both 0x8000 is replaced by 2^30 − 1. For example, X = (0x8000, 0), Y = (0x8000, 0) yields `p_re` = 0x7FFF.
- R8: With `rnd` high, 2^14 is added to the full-precision sum before the floor division by 2^15 and before saturation, for both parts.
- R9: A sum that falls outside the 16-bit range after scaling is clamped to 0x7FFF if positive or 0x8000 if negative.
- R10: If `re_en` was low at the sampling edge, `p_re` for that sample is 0x0000. If `im_en` was low, `p_im` is 0x0000.
- R11: While `rst_n` is low, `p_re`, `p_im` and `p_vld` are 0 and all captured operands and controls are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_re | input | 16 | Real part of X |
| x_im | input | 16 | Imaginary part of X |
| conj_x | input | 1 | Conjugate X; captured with X |
| x_ld | input | 1 | Load enable for the X register |
| y_re | input | 16 | Real part of Y |
| y_im | input | 16 | Imaginary part of Y |
| conj_y | input | 1 | Conjugate Y; captured with Y |
| y_ld | input | 1 | Load enable for the Y register |
| rnd | input | 1 | Round both result parts |
| re_en | input | 1 | Enable for the real output |
| im_en | input | 1 | Enable for the imaginary output |
| p_re | output | 16 | Real part of the product |
| p_im | output | 16 | Imaginary part of the product |
| p_vld | output | 1 | Result corresponds to a sample with a load |

## Verification
The hold and trap properties assume that the controls that are not captured with an operand (`rnd`, `re_en`, `im_en`) count as inputs that change the output, so any change to them resets the quiet-window count. The trap property also assumes the other imaginary parts are zero, so that only one partial product is involved. The timing properties count four sampled edges since reset before they apply, because earlier samples come from reset values. Stimulus changes only at falling edges and holds steady across each rising edge. The random stream leans toward 0x8000, 0x7FFF and 0, so that traps, saturation and conjugation of -1 are hit often, and it includes stretches with both loads low to exercise the hold condition.

// File: rtl/cplx_frac_mul.sv
module cplx_frac_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x_re,
  input  logic [W-1:0] x_im,
  input  logic         conj_x,
  input  logic         x_ld,
  input  logic [W-1:0] y_re,
  input  logic [W-1:0] y_im,
  input  logic         conj_y,
  input  logic         y_ld,
  input  logic         rnd,
  input  logic         re_en,
  input  logic         im_en,
  output logic [W-1:0] p_re,
  output logic [W-1:0] p_im,
  output logic         p_vld
);
  localparam int PW = 2 * W;
  localparam int SW = PW + 2;
  localparam logic signed [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0]  MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [PW-1:0] PTRAP = {2'b00, {(PW-2){1'b1}}};
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (W - 2);

  function automatic logic signed [W-1:0] neg_sat(input logic signed [W-1:0] v);
    return (v == MINV) ? MAXV : -v;
  endfunction

  function automatic logic signed [PW-1:0] fmul(input logic signed [W-1:0] a,
                                                input logic signed [W-1:0] b);
    logic signed [PW-1:0] p;
    p = a * b;
    return (a == MINV && b == MINV) ? PTRAP : p;
  endfunction

  function automatic logic signed [W-1:0] scale_sat(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] q;
    q = s >>> (W - 1);
    if (q > SW'(MAXV)) return MAXV;
    if (q < SW'(MINV)) return MINV;
    return q[W-1:0];
  endfunction

  logic signed [W-1:0] xr_q, xi_q, yr_q, yi_q;
  logic cx_q, cy_q, rnd_q, ree_q, ime_q, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xr_q <= '0; xi_q <= '0; cx_q <= 1'b0;
      yr_q <= '0; yi_q <= '0; cy_q <= 1'b0;
      rnd_q <= 1'b0; ree_q <= 1'b0; ime_q <= 1'b0; vld_q <= 1'b0;
    end else begin
      if (x_ld) begin
        xr_q <= x_re; xi_q <= x_im; cx_q <= conj_x;
      end
      if (y_ld) begin
        yr_q <= y_re; yi_q <= y_im; cy_q <= conj_y;
      end
      rnd_q <= rnd;
      ree_q <= re_en;
      ime_q <= im_en;
      vld_q <= x_ld | y_ld;
    end
  end

  wire logic signed [W-1:0] xi_c = cx_q ? neg_sat(xi_q) : xi_q;
  wire logic signed [W-1:0] yi_c = cy_q ? neg_sat(yi_q) : yi_q;

  logic signed [PW-1:0] rr_q, ii_q, ri_q, ir_q;
  logic rnd_1, ree_1, ime_1, vld_1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0; ii_q <= '0; ri_q <= '0; ir_q <= '0;
      rnd_1 <= 1'b0; ree_1 <= 1'b0; ime_1 <= 1'b0; vld_1 <= 1'b0;
    end else begin
      rr_q <= fmul(xr_q, yr_q);
      ii_q <= fmul(xi_c, yi_c);
      ri_q <= fmul(xr_q, yi_c);
      ir_q <= fmul(xi_c, yr_q);
      rnd_1 <= rnd_q; ree_1 <= ree_q; ime_1 <= ime_q; vld_1 <= vld_q;
    end
  end

  wire logic signed [SW-1:0] bias   = rnd_1 ? HALF : '0;
  wire logic signed [SW-1:0] sum_re = SW'(rr_q) - SW'(ii_q) + bias;
  wire logic signed [SW-1:0] sum_im = SW'(ri_q) + SW'(ir_q) + bias;

  logic signed [W-1:0] re_2, im_2;
  logic ree_2, ime_2, vld_2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re_2 <= '0; im_2 <= '0; ree_2 <= 1'b0; ime_2 <= 1'b0; vld_2 <= 1'b0;
    end else begin
      re_2 <= scale_sat(sum_re);
      im_2 <= scale_sat(sum_im);
      ree_2 <= ree_1; ime_2 <= ime_1; vld_2 <= vld_1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_re <= '0; p_im <= '0; p_vld <= 1'b0;
    end else begin
      p_re  <= ree_2 ? re_2 : '0;
      p_im  <= ime_2 ? im_2 : '0;
      p_vld <= vld_2;
    end
  end
endmodule

// File: rtl/cplx_frac_mul_chk.sv
module cplx_frac_mul_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] x_re,
  input logic [W-1:0] x_im,
  input logic         x_ld,
  input logic [W-1:0] y_re,
  input logic [W-1:0] y_im,
  input logic         y_ld,
  input logic         rnd,
  input logic         re_en,
  input logic         im_en,
  input logic [W-1:0] p_re,
  input logic [W-1:0] p_im,
  input logic         p_vld
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic [2:0] cyc, quiet;
  logic [2:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0; quiet <= '0; ctl_q <= '0;
    end else begin
      if (cyc != 3'd7) cyc <= cyc + 3'd1;
      ctl_q <= {rnd, re_en, im_en};
      if (x_ld || y_ld || ({rnd, re_en, im_en} != ctl_q)) quiet <= '0;
      else if (quiet != 3'd7) quiet <= quiet + 3'd1;
    end
  end

  assert_vld_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4) |-> (p_vld == $past(x_ld || y_ld, 4)));

  assert_hold_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5 && quiet >= 3'd4) |-> ($stable(p_re) && $stable(p_im)));

  assert_trap_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && $past(x_ld && y_ld && re_en && x_re == MINV && y_re == MINV &&
                          x_im == '0 && y_im == '0, 4)) |-> (p_re == MAXV));

  assert_re_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && !$past(re_en, 4)) |-> (p_re == '0));

  assert_im_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd4 && !$past(im_en, 4)) |-> (p_im == '0));
endmodule

bind cplx_frac_mul cplx_frac_mul_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .x_re(x_re), .x_im(x_im), .x_ld(x_ld),
  .y_re(y_re), .y_im(y_im), .y_ld(y_ld), .rnd(rnd), .re_en(re_en),
  .im_en(im_en), .p_re(p_re), .p_im(p_im), .p_vld(p_vld)
);

// File: tb/cplx_frac_mul_tb_top.sv
`timescale 1ns/1ps
module cplx_frac_mul_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
  logic conj_x = 0, conj_y = 0, x_ld = 0, y_ld = 0, rnd = 0, re_en = 0, im_en = 0;
  logic [15:0] p_re, p_im;
  logic p_vld;

  always #4 clk = ~clk;

  cplx_frac_mul dut_i (
    .clk(clk), .rst_n(rst_n), .x_re(x_re), .x_im(x_im), .conj_x(conj_x), .x_ld(x_ld),
    .y_re(y_re), .y_im(y_im), .conj_y(conj_y), .y_ld(y_ld), .rnd(rnd),
    .re_en(re_en), .im_en(im_en), .p_re(p_re), .p_im(p_im), .p_vld(p_vld)
  );

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  logic [15:0] mxr = 0, mxi = 0, myr = 0, myi = 0;
  bit mcx = 0, mcy = 0;
  logic [15:0] e_re[8], e_im[8];
  bit e_v[8];
  string t_re[8], t_im[8];

  function automatic longint neg_sat(input logic [15:0] v);
    return (v == 16'h8000) ? 32767 : -longint'($signed(v));
  endfunction

  function automatic longint fmul(input longint a, input longint b);
    return (a == -32768 && b == -32768) ? 64'd1073741823 : a * b;
  endfunction

  function automatic logic [15:0] fin(input longint s, input bit r);
    longint q;
    q = (s + (r ? 16384 : 0)) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q[15:0];
  endfunction

  task automatic chk(input string tg, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h (step %0d)", tg, act, exp, n);
    end
  endtask

  task automatic step(input bit xl, input logic [15:0] xr, input logic [15:0] xi, input bit cx,
                      input bit yl, input logic [15:0] yr, input logic [15:0] yi, input bit cy,
                      input bit rd, input bit ree, input bit ime,
                      input string tr, input string ti);
    longint a_r, a_i, b_r, b_i;
    int s;
    @(negedge clk);
    if (n >= 4) begin
      s = (n - 4) % 8;
      chk(t_re[s], p_re, e_re[s]);
      chk(t_im[s], p_im, e_im[s]);
      chk("R3 valid", {15'd0, p_vld}, {15'd0, e_v[s]});
    end
    x_ld = xl; x_re = xr; x_im = xi; conj_x = cx;
    y_ld = yl; y_re = yr; y_im = yi; conj_y = cy;
    rnd = rd; re_en = ree; im_en = ime;
    if (xl) begin mxr = xr; mxi = xi; mcx = cx; end
    if (yl) begin myr = yr; myi = yi; mcy = cy; end
    a_r = longint'($signed(mxr));
    a_i = mcx ? neg_sat(mxi) : longint'($signed(mxi));
    b_r = longint'($signed(myr));
    b_i = mcy ? neg_sat(myi) : longint'($signed(myi));
    s = n % 8;
    e_re[s] = ree ? fin(fmul(a_r, b_r) - fmul(a_i, b_i), rd) : 16'h0000;
    e_im[s] = ime ? fin(fmul(a_r, b_i) + fmul(a_i, b_r), rd) : 16'h0000;
    e_v[s] = xl | yl;
    t_re[s] = tr;
    t_im[s] = ti;
    n++;
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 6)
      0: return 16'h8000;
      1: return 16'h7FFF;
      2: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #3;
    chk("R11 reset re", p_re, 16'h0000);
    chk("R11 reset im", p_im, 16'h0000);
    chk("R11 reset vld", {15'd0, p_vld}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    step(1, 16'h4000, 16'h0000, 0, 1, 16'h4000, 16'h0000, 0, 0, 1, 1, "R1 basic", "R2 basic");
    step(1, 16'h2000, 16'h1000, 0, 1, 16'h1000, 16'h3000, 0, 0, 1, 1, "R1 mix", "R2 mix");
    step(1, 16'h8000, 16'h0000, 0, 1, 16'h8000, 16'h0000, 0, 0, 1, 1, "R7 trap re", "R7 trap im");
    step(1, 16'h0000, 16'h8000, 0, 1, 16'h0000, 16'h8000, 0, 1, 1, 1, "R7 trap ii", "R7 im");
    step(1, 16'h0000, 16'h8000, 1, 1, 16'h0000, 16'h4000, 0, 0, 1, 1, "R5 conj x", "R5 conj x im");
    step(1, 16'h3000, 16'h1234, 1, 1, 16'h2000, 16'h0F00, 0, 0, 1, 1, "R5 conj", "R5 conj im");
    step(1, 16'h4000, 16'h0000, 0, 1, 16'h0000, 16'h8000, 1, 0, 1, 1, "R6 conj y", "R6 conj y im");
    step(1, 16'h1111, 16'h2222, 1, 1, 16'h3333, 16'hC444, 1, 0, 1, 1, "R6 both", "R6 both im");
    step(1, 16'h0003, 16'h0000, 0, 1, 16'h4000, 16'h0000, 0, 1, 1, 1, "R8 rnd on", "R8 im");
    step(1, 16'h0003, 16'h0000, 0, 1, 16'h4000, 16'h0000, 0, 0, 1, 1, "R8 rnd off", "R8 im");
    step(1, 16'hFFFD, 16'h0001, 0, 1, 16'h4000, 16'h4000, 0, 1, 1, 1, "R8 neg rnd", "R8 im rnd");
    step(1, 16'h7FFF, 16'h7FFF, 0, 1, 16'h7FFF, 16'h8001, 0, 0, 1, 1, "R9 sat pos", "R9 im");
    step(1, 16'h8000, 16'h8000, 0, 1, 16'h7FFF, 16'h7FFF, 0, 1, 1, 1, "R9 re", "R9 sat neg");
    step(1, 16'h4000, 16'h4000, 0, 1, 16'h4000, 16'h2000, 0, 0, 0, 1, "R10 re off", "R10 im on");
    step(1, 16'h4000, 16'h4000, 0, 1, 16'h4000, 16'h2000, 0, 0, 1, 0, "R10 re on", "R10 im off");
    step(0, 16'h1234, 16'h5678, 1, 1, 16'h2000, 16'h0000, 0, 0, 1, 1, "R4 x held", "R4 x held im");
    step(1, 16'h2000, 16'h0000, 0, 0, 16'h7777, 16'h8000, 1, 0, 1, 1, "R4 y held", "R4 y held im");
    for (int i = 0; i < 5; i++)
      step(0, 16'($urandom), 16'($urandom), 1, 0, 16'($urandom), 16'($urandom), 1,
           0, 1, 1, "R4 idle", "R4 idle im");

    for (int i = 0; i < 600; i++) begin
      automatic bit xl = ($urandom % 4) != 0;
      automatic bit yl = ($urandom % 4) != 0;
      step(xl, pick(), pick(), 1'($urandom), yl, pick(), pick(), 1'($urandom),
           1'($urandom), ($urandom % 8) != 0, ($urandom % 8) != 0, "R1 rand", "R2 rand");
    end
    for (int i = 0; i < 4; i++)
      step(0, 16'h0, 16'h0, 0, 0, 16'h0, 16'h0, 0, 0, 1, 1, "R1 flush", "R2 flush");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule